// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch about to be fetched will be taken. It keeps two pieces of state:

- a shift register holding the directions of the most recent resolved branches;
- a table of two-bit saturating counters.

The table is addressed by folding the history together with word-aligned bits of the fetch address using bitwise XOR. Because the branch address is part of the address, two branches that arrive under the same history usually train different counters.

Using it takes two steps. At fetch, the front end presents the program counter. In the same cycle it gets back a direction guess and the table index that produced the guess, and it carries that index down the pipeline with the branch. When the branch resolves, the back end returns the index and the real direction. The block then moves the addressed counter one step toward that direction and shifts the direction into the history.

Lookups are combinational reads of registered state. All writes take effect at the clock edge.

Top module: `branch_dir_pred`

## Requirements
- R1: When `up_valid` is high at a clock edge, the history becomes `{history[HIST_W-2:0], up_taken}`. Bit 0 holds the newest direction, where 1 means taken. After a taken branch, an oldest-to-newest pattern taken, taken, taken, not-taken (`4'b1110`) becomes `4'b1101`.
- R2: `lk_index` equals the history XOR `lk_pc[HIST_W+1:2]`, in the same cycle as `lk_pc`.
- R3: A counter never wraps. Taken at 3 (`2'b11`) leaves it at 3, and not-taken at 0 (`2'b00`) leaves it at 0.
- R4: `lk_taken` is the upper bit of the counter at `lk_index`. Values 3 and 2 predict taken; values 1 and 0 predict not-taken.
- R5: A taken outcome adds one to the addressed counter and a not-taken outcome subtracts one. From a strong state, the guess therefore reverses only after two opposite outcomes in a row.
- R6: A synchronous active-high `rst` clears the history to zero and sets every counter to 1 (weakly not-taken).
- R7: An update trains only the counter named by `up_index`, whatever the current history and lookup address are. Every other counter is unchanged.
- R8: If a lookup and an update address the same counter in the same cycle, `lk_taken` reflects the counter value from before that update.
- R9: When `up_valid` is low, lookups leave the history and every counter unchanged.
- R10: A counter that starts at 2 and sees strictly alternating outcomes is right on half of the alternating branches. A counter at 3 that sees a four-iteration loop pattern is right on three of every four branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address of the branch being predicted |
| lk_index | output | HIST_W | Counter index used for this lookup, to be carried to the update |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_index | input | HIST_W | Index captured at lookup time for the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench builds the predictor with `HIST_W=4` and `PC_W=16`, which gives a 16-counter table and a 4-bit history. At that size, every history value and every counter can be reached in a few dozen cycles. Aliasing between unrelated addresses also happens often, so a randomized stretch can exercise training of every counter through both saturation limits. The small width also keeps the hashing easy to follow: the TTTN to TTNT history example can be checked directly, and the chosen lookup addresses land on a trained entry under any history.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    // Two-bit hysteresis counter states; the upper bit is the direction guess.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WNT;

    // Low address bits dropped before hashing (word-aligned instructions).
    localparam int unsigned PC_ALIGN_BITS = 2;

    // Move one step toward the resolved direction, stopping at the ends.
    function automatic ctr_state_e ctr_step(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_guess(input ctr_state_e cur);
        return (cur == CTR_WT) || (cur == CTR_ST);
    endfunction

endpackage

// File: rtl/bdp_history.sv
module bdp_history #(
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/bdp_hash.sv
module bdp_hash #(
    parameter int unsigned HIST_W = 10,
    parameter int unsigned PC_W   = 32
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [HIST_W-1:0] hist_i,
    output logic [HIST_W-1:0] index_o
);

    import bdp_pkg::*;

    localparam int unsigned LO = PC_ALIGN_BITS;
    localparam int unsigned HI = LO + HIST_W - 1;

    logic [HIST_W-1:0] pc_field;
    logic              unused_pc_bits;

    assign pc_field       = pc_i[HI:LO];
    assign unused_pc_bits = ^{pc_i[PC_W-1:HI+1], pc_i[LO-1:0]};
    assign index_o        = hist_i ^ pc_field;

endmodule

// File: rtl/bdp_table.sv
module bdp_table #(
    parameter int unsigned HIST_W = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [HIST_W-1:0]                 rd_index,
    output bdp_pkg::ctr_state_e               rd_ctr,
    input  logic                              wr_en,
    input  logic [HIST_W-1:0]                 wr_index,
    input  logic                              wr_taken,
    output logic [(1<<HIST_W)-1:0][1:0]       tbl_o
);

    import bdp_pkg::*;

    localparam int unsigned ENTRIES = 1 << HIST_W;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        ctr_state_e ent_q;
        logic       hit;

        assign hit = wr_en && (wr_index == HIST_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= CTR_RESET;
            end else if (hit) begin
                ent_q <= ctr_step(ent_q, wr_taken);
            end
        end

        assign tbl_o[e] = ent_q;
    end

    // Combinational read of registered state: a same-cycle write is not yet visible.
    assign rd_ctr = ctr_state_e'(tbl_o[rd_index]);

endmodule

// File: rtl/branch_dir_pred.sv
module branch_dir_pred #(
    parameter int unsigned HIST_W = 10,
    parameter int unsigned PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    output logic [HIST_W-1:0] lk_index,
    output logic              lk_taken,
    input  logic              up_valid,
    input  logic [HIST_W-1:0] up_index,
    input  logic              up_taken
);

    import bdp_pkg::*;

    localparam int unsigned ENTRIES = 1 << HIST_W;

    logic [HIST_W-1:0]         ghr_q;
    logic [ENTRIES-1:0][1:0]   ctr_tbl;
    ctr_state_e                lk_ctr;

    bdp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (up_valid),
        .shift_bit (up_taken),
        .hist_o    (ghr_q)
    );

    bdp_hash #(.HIST_W(HIST_W), .PC_W(PC_W)) u_hash (
        .pc_i    (lk_pc),
        .hist_i  (ghr_q),
        .index_o (lk_index)
    );

    bdp_table #(.HIST_W(HIST_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_index (lk_index),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_index (up_index),
        .wr_taken (up_taken),
        .tbl_o    (ctr_tbl)
    );

    assign lk_taken = ctr_guess(lk_ctr);

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int unsigned HIST_W = 10
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            up_valid,
    input logic                            up_taken,
    input logic [HIST_W-1:0]               up_index,
    input logic [HIST_W-1:0]               lk_index,
    input logic                            lk_taken,
    input logic [HIST_W-1:0]               ghr,
    input logic [(1<<HIST_W)-1:0][1:0]     tbl
);

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(up_taken)}); // R1

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(ghr)); // R9

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(tbl)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && tbl[up_index] == 2'b11)
        |=> tbl[$past(up_index)] == 2'b11); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && tbl[up_index] == 2'b00)
        |=> tbl[$past(up_index)] == 2'b00); // R3

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && tbl[up_index] != 2'b11)
        |=> tbl[$past(up_index)] == $past(tbl[up_index]) + 2'd1); // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && tbl[up_index] != 2'b00)
        |=> tbl[$past(up_index)] == $past(tbl[up_index]) - 2'd1); // R5

    AST_GUESS_MSB: assert property (@(posedge clk) disable iff (rst)
        lk_taken == tbl[lk_index][1]); // R4

endmodule

bind branch_dir_pred bdp_checker #(.HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .up_index (up_index),
    .lk_index (lk_index),
    .lk_taken (lk_taken),
    .ghr      (ghr_q),
    .tbl      (ctr_tbl)
);

// File: tb/sim_branch_dir_pred.sv
`timescale 1ns/100ps
module sim_branch_dir_pred;

    localparam int HW = 4;
    localparam int PW = 16;
    localparam int NE = 1 << HW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] lk_pc = '0;
    logic [HW-1:0] lk_index;
    logic          lk_taken;
    logic          up_valid = 1'b0;
    logic [HW-1:0] up_index = '0;
    logic          up_taken = 1'b0;

    always #2.5 clk = ~clk;

    branch_dir_pred #(.HIST_W(HW), .PC_W(PW)) u0 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_index(lk_index), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken)
    );

    typedef struct {
        logic [HW-1:0] idx;
        logic          taken;
        logic          score;
        logic          outcome;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0;
    int            fails  = 0;
    int            hits   = 0;
    logic [HW-1:0] ghr_m;
    logic [1:0]    ctr_m [NE];

    function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    // Driver: present one cycle of stimulus, push the expected lookup, advance the model.
    task automatic step(input logic [PW-1:0] pc, input logic uv, input logic [HW-1:0] ui,
                        input logic ut, input string tag, input logic score = 1'b0);
        exp_t e;
        @(negedge clk);
        lk_pc = pc; up_valid = uv; up_index = ui; up_taken = ut;
        e.idx = ghr_m ^ pc[HW+1:2];
        e.taken = ctr_m[e.idx][1];
        e.score = score;
        e.outcome = ut;
        e.tag = tag;
        sb_q.push_back(e);
        if (uv) begin
            ctr_m[ui] = sat(ctr_m[ui], ut);
            ghr_m = {ghr_m[HW-2:0], ut};
        end
    endtask

    function automatic logic [PW-1:0] pc_for(input logic [HW-1:0] idx);
        return PW'(idx ^ ghr_m) << 2;
    endfunction

    // Train the entry the lookup also addresses (same-cycle case).
    task automatic train_hit(input logic [HW-1:0] idx, input logic t, input string tag,
                             input logic score = 1'b0);
        step(pc_for(idx), 1'b1, idx, t, tag, score);
    endtask

    task automatic probe(input logic [HW-1:0] idx, input string tag);
        step(pc_for(idx), 1'b0, '0, 1'b0, tag);
    endtask

    task automatic drain;
        @(negedge clk);
        up_valid = 1'b0;
        #2;
    endtask

    // Monitor: compare design outputs against queued expectations, away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (lk_index !== e.idx || lk_taken !== e.taken) begin
                    fails++;
                    $display("FAIL %s: index=%0d taken=%0b expected index=%0d taken=%0b",
                             e.tag, lk_index, lk_taken, e.idx, e.taken);
                end
                if (e.score && lk_taken === e.outcome) hits++;
            end
        end
    end

    task automatic check_hits(input int want, input string tag);
        checks++;
        if (hits != want) begin
            fails++;
            $display("FAIL %s: correct guesses=%0d expected=%0d", tag, hits, want);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        ghr_m = '0;
        for (int i = 0; i < NE; i++) ctr_m[i] = 2'b01;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6 / R2: reset state, index is the plain address field under zero history
        step(16'h0000, 0, 0, 0, "R6 reset entry 0");
        step(16'h003C, 0, 0, 0, "R6 reset entry 15 R2");
        step(16'hFFE8, 0, 0, 0, "R2 upper bits ignored");

        // R1: history TTTN then TTNT, observed through the index with address field 0
        step(16'h0000, 1, 4'd0, 1, "R1 shift T");
        step(16'h0000, 1, 4'd0, 1, "R1 shift T");
        step(16'h0000, 1, 4'd0, 1, "R1 shift T");
        step(16'h0000, 1, 4'd0, 0, "R1 shift N");
        step(16'h0000, 1, 4'd0, 1, "R1 TTTN to TTNT");
        step(16'h0000, 0, 0, 0, "R1 history 1101");

        // R9: lookups alone change nothing
        for (int i = 0; i < 6; i++) step(PW'(i * 20), 0, 0, 0, "R9 lookup only");
        step(16'h0000, 0, 0, 0, "R9 history held");

        // R3/R4/R5/R8: walk entry 9 up, saturate, then down
        train_hit(4'd9, 1, "R8 R5 up from 1");
        train_hit(4'd9, 1, "R4 R5 up from 2");
        train_hit(4'd9, 1, "R3 at 3");
        train_hit(4'd9, 0, "R3 held at 3");
        train_hit(4'd9, 0, "R5 one miss keeps taken");
        probe(4'd9, "R5 two misses flip");
        train_hit(4'd9, 0, "R5 down to 0");
        train_hit(4'd9, 0, "R3 at 0");
        probe(4'd9, "R3 held at 0");
        train_hit(4'd9, 1, "R5 up from 0");
        probe(4'd9, "R4 value 1 not taken");

        // R7: train entry 3 while looking up elsewhere, then look at both
        step(pc_for(4'd7), 1, 4'd3, 1, "R7 other entry");
        step(pc_for(4'd7), 1, 4'd3, 1, "R7 other entry");
        probe(4'd3, "R7 trained entry");
        probe(4'd7, "R7 untouched entry");

        // R10: alternating outcomes from value 2 on entry 12
        train_hit(4'd12, 1, "R10 prime");
        drain();
        hits = 0;
        for (int i = 0; i < 8; i++) train_hit(4'd12, (i % 2) == 0, "R10 alternating", 1'b1);
        drain();
        check_hits(4, "R10 alternating half right");

        // R10: four-iteration loop on entry 6 from value 3
        train_hit(4'd6, 1, "R10 prime");
        train_hit(4'd6, 1, "R10 prime");
        drain();
        hits = 0;
        for (int i = 0; i < 12; i++) train_hit(4'd6, (i % 4) != 3, "R10 loop", 1'b1);
        drain();
        check_hits(9, "R10 loop three of four");

        // Mixed traffic: R7 R3 R5 R8 across every entry
        for (int i = 0; i < 300; i++) begin
            logic [PW-1:0] pc;
            logic [HW-1:0] ui;
            logic uv, ut;
            pc = PW'($urandom);
            ui = HW'($urandom);
            uv = ($urandom % 4) != 0;
            ut = ($urandom % 3) != 0;
            step(pc, uv, ui, ut, "R7 mixed traffic");
        end
        drain();

        // R6: reset again restores the initial state
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ghr_m = '0;
        for (int i = 0; i < NE; i++) ctr_m[i] = 2'b01;
        step(16'h0018, 0, 0, 0, "R6 second reset");
        step(16'h0024, 0, 0, 0, "R6 second reset");
        drain();

        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: leftover=%0d expected=0", sb_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule